// File: doc/BRIEF.md
# Two-Level Translation Walker

This block turns a 32-bit I/O virtual address into a 32-bit physical address. It walks a two-level page table held in memory. The top 12 address bits select a first-level entry, the next 8 bits select a second-level entry, and the low 12 bits pass through unchanged as the offset within a 4 KB page. Each leaf entry carries a 4-bit domain index. That index selects one of sixteen programmable read/write permission pairs, and the block checks the access against that pair before it returns a result.

Requests enter on a valid/ready port. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. Results leave on a valid/ready port. Once `rsp_valid` rises, it stays high and `rsp_paddr` stays unchanged until `rsp_ready` is seen high at a clock edge. Table fetches use a read request channel with valid/ready. `mem_rd_valid` and `mem_rd_addr` stay unchanged until `mem_rd_ready` is seen high. After that, the memory returns the entry with a one-cycle `mem_rsp_valid` strobe, with any latency.

The walker sends no back-pressure on the fetch data: it is always able to take it. A walk that fails produces no response. Instead it latches a fault cause and the faulting address, and holds them until `flt_clear`. The table base and bypass inputs are sampled when a request is accepted. The permission inputs are sampled when the leaf entry arrives.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_rd_valid` and `flt_valid` are 0; `flt_cause` is 0.
- R2: The first fetch reads address `tbl_base + vaddr[31:20]*4`. A first-level entry is valid only when its bits 1:0 equal 2'b01, and its bits 31:10 give the second-level table address.
- R3: The second fetch reads address `{entry1[31:10], vaddr[19:12], 2'b00}`.
- R4: A successful walk returns `{entry2[31:12], vaddr[11:0]}`. A second-level entry is valid when bit 1 is set, and its bits 7:4 are the domain index.
- R5: A read needs `dom_rd_allow[d]` and a write needs `dom_wr_allow[d]`, where d is the domain index. A denied access gives fault cause 3 and no response.
- R6: An invalid first-level entry gives fault cause 1 with `flt_addr` equal to the request address, issues no second fetch and gives no response.
- R7: An invalid second-level entry gives fault cause 2 with `flt_addr` equal to the request address, and gives no response.
- R8: With `bypass_en` high at acceptance, the response equals the request address, appears in the cycle after acceptance, and no fetch is issued.
- R9: A fault stays latched until `flt_clear`. While it is latched, `req_ready` is 0 and request attempts start no fetch. Cause 0 means no fault.
- R10: Only one walk is in flight. `req_ready` stays 0 from acceptance until the response handshake or the fault.
- R11: `mem_rd_valid`/`mem_rd_addr` and `rsp_valid`/`rsp_paddr` hold steady while their ready input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Translated address valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address |
| mem_rd_valid | output | 1 | Table entry fetch request |
| mem_rd_ready | input | 1 | Memory accepts the fetch |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Fetched entry strobe |
| mem_rsp_data | input | 32 | Fetched entry |
| tbl_base | input | 32 | First-level table base address |
| bypass_en | input | 1 | Pass addresses through untranslated |
| dom_rd_allow | input | 16 | Per-domain read permission |
| dom_wr_allow | input | 16 | Per-domain write permission |
| flt_valid | output | 1 | A fault is latched |
| flt_cause | output | 2 | 1 first-level, 2 second-level, 3 permission |
| flt_addr | output | 32 | Virtual address of the faulting request |
| flt_clear | input | 1 | Clears the latched fault |

## Verification
All times below count from the clock edge that accepts a request.

- A bypass response is due one edge after acceptance.
- A translated walk asserts its first fetch one edge after acceptance.
- Each fetch moves the walker on one edge after the `mem_rd_ready` handshake.
- The walker reacts one edge after the data strobe, either by issuing the next fetch, by showing the fault latched, or by raising the response.

The bench drives every input at the falling edge and samples outputs at the next falling edge. Each check therefore lands exactly one register stage after the stimulus that causes it. Fetch and response ready are held low for a cycle in every walk, so the held values are checked too.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_RESP
  } walk_st_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_L1   = 2'd1,
    CAUSE_L2   = 2'd2,
    CAUSE_PERM = 2'd3
  } flt_cause_e;

  // entry field positions decoded by the walker
  localparam int DIR_VALID_LSB = 0;
  localparam logic [1:0] DIR_VALID_CODE = 2'b01;
  localparam int LEAF_VALID_BIT = 1;
  localparam int DOM_LSB = 4;
endpackage

// File: rtl/xw_perm.sv
module xw_perm #(
  parameter int DOM_W = 4,
  localparam int NUM_DOM = 1 << DOM_W
) (
  input  logic [DOM_W-1:0]   dom_idx,
  input  logic               is_write,
  input  logic [NUM_DOM-1:0] rd_allow,
  input  logic [NUM_DOM-1:0] wr_allow,
  output logic               allow
);
  logic [NUM_DOM-1:0] grant;

  // per-domain grant for the current access direction
  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    assign grant[g] = is_write ? wr_allow[g] : rd_allow[g];
  end

  assign allow = grant[dom_idx];
endmodule

// File: rtl/xw_fault.sv
module xw_fault #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flt_set,
  input  logic [1:0]    flt_code,
  input  logic [AW-1:0] flt_va,
  input  logic          flt_clear,
  output logic          flt_valid,
  output logic [1:0]    flt_cause,
  output logic [AW-1:0] flt_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_cause <= 2'd0;
      flt_addr  <= '0;
    end else if (flt_set) begin
      flt_cause <= flt_code;
      flt_addr  <= flt_va;
    end else if (flt_clear) begin
      flt_cause <= 2'd0;
    end
  end

  assign flt_valid = (flt_cause != 2'd0);

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !flt_clear |=> flt_valid && $stable(flt_addr) && $stable(flt_cause)) // R9
    else $error("fault changed without clear");

  AST_FAULT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flt_clear && !flt_set |=> !flt_valid) // R9
    else $error("fault not cleared");

  AST_NO_SET_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    flt_set |-> !flt_valid) // R9
    else $error("walk faulted while a fault was held");
endmodule

// File: rtl/xw_walk_ctrl.sv
module xw_walk_ctrl
  import xw_pkg::*;
#(
  parameter int AW       = 32,
  parameter int OFS_W    = 12,
  parameter int L2_IDX_W = 8,
  parameter int DOM_W    = 4,
  localparam int L1_IDX_W = AW - OFS_W - L2_IDX_W,
  localparam int PTR_LSB  = L2_IDX_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_vaddr,
  input  logic             req_write,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [AW-1:0]    rsp_paddr,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [AW-1:0]    mem_rsp_data,
  input  logic [AW-1:0]    tbl_base,
  input  logic             bypass_en,
  input  logic             flt_pending,
  output logic [DOM_W-1:0] dom_idx,
  output logic             acc_write,
  input  logic             perm_ok,
  output logic             flt_set,
  output logic [1:0]       flt_code,
  output logic [AW-1:0]    flt_va
);
  walk_st_e      st_q;
  logic [AW-1:0] va_q;
  logic [AW-1:0] pa_q;
  logic [AW-1:0] fetch_q;
  logic          wr_q;
  logic          dir_ok;
  logic          leaf_ok;
  logic          unused_bits;

  assign dir_ok  = mem_rsp_data[DIR_VALID_LSB +: 2] == DIR_VALID_CODE;
  assign leaf_ok = mem_rsp_data[LEAF_VALID_BIT];
  assign dom_idx = mem_rsp_data[DOM_LSB +: DOM_W];
  assign acc_write = wr_q;
  assign unused_bits = ^{mem_rsp_data[PTR_LSB-1:DOM_LSB+DOM_W], mem_rsp_data[DOM_LSB-1:2]};

  assign req_ready    = (st_q == ST_IDLE) && !flt_pending;
  assign rsp_valid    = (st_q == ST_RESP);
  assign rsp_paddr    = pa_q;
  assign mem_rd_valid = (st_q == ST_L1_REQ) || (st_q == ST_L2_REQ);
  assign mem_rd_addr  = fetch_q;
  assign flt_va       = va_q;

  always_comb begin
    flt_set  = 1'b0;
    flt_code = CAUSE_NONE;
    if (mem_rsp_valid && st_q == ST_L1_WAIT && !dir_ok) begin
      flt_set  = 1'b1;
      flt_code = CAUSE_L1;
    end else if (mem_rsp_valid && st_q == ST_L2_WAIT) begin
      if (!leaf_ok) begin
        flt_set  = 1'b1;
        flt_code = CAUSE_L2;
      end else if (!perm_ok) begin
        flt_set  = 1'b1;
        flt_code = CAUSE_PERM;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      pa_q    <= '0;
      fetch_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            va_q    <= req_vaddr;
            wr_q    <= req_write;
            fetch_q <= tbl_base + {{(AW-L1_IDX_W-2){1'b0}}, req_vaddr[AW-1 -: L1_IDX_W], 2'b00};
            if (bypass_en) begin
              pa_q <= req_vaddr;
              st_q <= ST_RESP;
            end else begin
              st_q <= ST_L1_REQ;
            end
          end
        end
        ST_L1_REQ: if (mem_rd_ready) st_q <= ST_L1_WAIT;
        ST_L1_WAIT: begin
          if (mem_rsp_valid) begin
            if (dir_ok) begin
              fetch_q <= {mem_rsp_data[AW-1:PTR_LSB], va_q[OFS_W +: L2_IDX_W], 2'b00};
              st_q    <= ST_L2_REQ;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_L2_REQ: if (mem_rd_ready) st_q <= ST_L2_WAIT;
        ST_L2_WAIT: begin
          if (mem_rsp_valid) begin
            if (leaf_ok && perm_ok) begin
              pa_q <= {mem_rsp_data[AW-1:OFS_W], va_q[OFS_W-1:0]};
              st_q <= ST_RESP;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)) // R11
    else $error("fetch request dropped or changed");

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)) // R11
    else $error("response dropped or changed");

  AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_rd_valid) // R10
    else $error("request accepted while busy");

  AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_paddr[OFS_W-1:0] == va_q[OFS_W-1:0]) // R4
    else $error("page offset not preserved");

  AST_NO_RESP_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    flt_set |=> !rsp_valid && !mem_rd_valid) // R6
    else $error("walk continued after fault");
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int AW       = 32,
  parameter int OFS_W    = 12,
  parameter int L2_IDX_W = 8,
  parameter int DOM_W    = 4,
  localparam int NUM_DOM = 1 << DOM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_vaddr,
  input  logic               req_write,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [AW-1:0]      rsp_paddr,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [AW-1:0]      mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [AW-1:0]      mem_rsp_data,
  input  logic [AW-1:0]      tbl_base,
  input  logic               bypass_en,
  input  logic [NUM_DOM-1:0] dom_rd_allow,
  input  logic [NUM_DOM-1:0] dom_wr_allow,
  output logic               flt_valid,
  output logic [1:0]         flt_cause,
  output logic [AW-1:0]      flt_addr,
  input  logic               flt_clear
);
  logic [DOM_W-1:0] dom_idx;
  logic             acc_write;
  logic             perm_ok;
  logic             flt_set;
  logic [1:0]       flt_code;
  logic [AW-1:0]    flt_va;

  xw_walk_ctrl #(.AW(AW), .OFS_W(OFS_W), .L2_IDX_W(L2_IDX_W), .DOM_W(DOM_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tbl_base(tbl_base), .bypass_en(bypass_en), .flt_pending(flt_valid),
    .dom_idx(dom_idx), .acc_write(acc_write), .perm_ok(perm_ok),
    .flt_set(flt_set), .flt_code(flt_code), .flt_va(flt_va)
  );

  xw_perm #(.DOM_W(DOM_W)) u_perm (
    .dom_idx(dom_idx), .is_write(acc_write),
    .rd_allow(dom_rd_allow), .wr_allow(dom_wr_allow), .allow(perm_ok)
  );

  xw_fault #(.AW(AW)) u_fault (
    .clk(clk), .rst_n(rst_n),
    .flt_set(flt_set), .flt_code(flt_code), .flt_va(flt_va), .flt_clear(flt_clear),
    .flt_valid(flt_valid), .flt_cause(flt_cause), .flt_addr(flt_addr)
  );
endmodule

// File: tb/xlat_walker_tb_top.sv
module xlat_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, rsp_valid, mem_rd_valid, flt_valid;
  logic [31:0] rsp_paddr, mem_rd_addr, flt_addr;
  logic [1:0]  flt_cause;
  logic        mem_rd_ready = 1'b0, mem_rsp_valid = 1'b0, bypass_en = 1'b0, flt_clear = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] tbl_base = 32'h8000_4000;
  logic [15:0] dom_rd_allow = 16'h0003;   // domain 0 and 1 readable
  logic [15:0] dom_wr_allow = 16'h0005;   // domain 0 and 2 writable

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlat_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .tbl_base(tbl_base), .bypass_en(bypass_en),
    .dom_rd_allow(dom_rd_allow), .dom_wr_allow(dom_wr_allow),
    .flt_valid(flt_valid), .flt_cause(flt_cause), .flt_addr(flt_addr), .flt_clear(flt_clear)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        byp;
    logic [31:0] l1e;
    logic [31:0] l2e;
    logic [1:0]  cause;
    logic [31:0] pa;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 1'b0, 1'b0, 32'h4000_0401, 32'h0ABC_D002, 2'd0, 32'h0ABC_D678},
    '{32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0000_FC01, 32'hFFFF_F022, 2'd0, 32'hFFFF_FFFF},
    '{32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 2'd1, 32'h0},
    '{32'h0010_1ABC, 1'b0, 1'b0, 32'h1234_5403, 32'h0000_0000, 2'd1, 32'h0},
    '{32'h0020_2123, 1'b0, 1'b0, 32'h2000_0001, 32'h3333_3001, 2'd2, 32'h0},
    '{32'h0030_3456, 1'b1, 1'b0, 32'h2000_0401, 32'h4444_4012, 2'd3, 32'h0},
    '{32'h0040_4FFF, 1'b0, 1'b0, 32'h2000_0401, 32'h5555_5022, 2'd3, 32'h0},
    '{32'h0050_5001, 1'b0, 1'b0, 32'h2000_0801, 32'h6666_6012, 2'd0, 32'h6666_6001},
    '{32'hDEAD_BEEF, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0000, 2'd0, 32'hDEAD_BEEF},
    '{32'h0060_6000, 1'b0, 1'b0, 32'h2000_0401, 32'h7777_7032, 2'd3, 32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_resp(input logic [31:0] pa, input string req);
    chk(rsp_valid === 1'b1, req, {31'b0, rsp_valid}, 32'd1);
    chk(rsp_paddr === pa, req, rsp_paddr, pa);
    @(negedge clk);   // consumer stalls one cycle
    chk(rsp_valid === 1'b1 && rsp_paddr === pa, "R11", rsp_paddr, pa);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid === 1'b0, "R10", {31'b0, rsp_valid}, 32'd0);
    chk(req_ready === 1'b1, "R10", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic finish_fault(input logic [1:0] cause, input logic [31:0] va, input string req);
    chk(flt_valid === 1'b1 && flt_cause === cause, req, {30'b0, flt_cause}, {30'b0, cause});
    chk(flt_addr === va, req, flt_addr, va);
    chk(rsp_valid === 1'b0, req, {31'b0, rsp_valid}, 32'd0);
    // request attempts while the fault is held are ignored (R9)
    req_valid = 1'b1;
    req_vaddr = 32'hAAAA_0000;
    @(negedge clk);
    @(negedge clk);
    chk(req_ready === 1'b0, "R9", {31'b0, req_ready}, 32'd0);
    chk(mem_rd_valid === 1'b0 && rsp_valid === 1'b0, "R9", {31'b0, mem_rd_valid}, 32'd0);
    chk(flt_addr === va, "R9", flt_addr, va);
    req_valid = 1'b0;
    flt_clear = 1'b1;
    @(negedge clk);
    flt_clear = 1'b0;
    chk(flt_valid === 1'b0 && flt_cause === 2'd0, "R9", {30'b0, flt_cause}, 32'd0);
    chk(req_ready === 1'b1, "R9", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] a1, a2;
    string tag;
    a1 = tbl_base + {18'b0, v.va[31:20], 2'b00};          // R2
    a2 = {v.l1e[31:10], v.va[19:12], 2'b00};              // R3
    tag = (v.cause == 2'd0) ? "R4" : (v.cause == 2'd1) ? "R6" : (v.cause == 2'd2) ? "R7" : "R5";
    @(negedge clk);
    bypass_en = v.byp;
    req_valid = 1'b1;
    req_vaddr = v.va;
    req_write = v.wr;
    chk(req_ready === 1'b1, "R10", {31'b0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R10", {31'b0, req_ready}, 32'd0);
    if (v.byp) begin
      chk(mem_rd_valid === 1'b0, "R8", {31'b0, mem_rd_valid}, 32'd0);
      finish_resp(v.pa, "R8");
      return;
    end
    chk(mem_rd_valid === 1'b1 && mem_rd_addr === a1, "R2", mem_rd_addr, a1);
    @(negedge clk);   // memory stalls one cycle
    chk(mem_rd_valid === 1'b1 && mem_rd_addr === a1, "R11", mem_rd_addr, a1);
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    chk(mem_rd_valid === 1'b0, "R10", {31'b0, mem_rd_valid}, 32'd0);
    mem_rsp_valid = 1'b1;
    mem_rsp_data = v.l1e;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    if (v.cause == 2'd1) begin
      chk(mem_rd_valid === 1'b0, "R6", {31'b0, mem_rd_valid}, 32'd0);
      finish_fault(v.cause, v.va, tag);
      return;
    end
    chk(mem_rd_valid === 1'b1 && mem_rd_addr === a2, "R3", mem_rd_addr, a2);
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    mem_rsp_valid = 1'b1;
    mem_rsp_data = v.l2e;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    if (v.cause != 2'd0) finish_fault(v.cause, v.va, tag);
    else finish_resp(v.pa, tag);
  endtask

  initial begin
    #5;
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_valid === 1'b0 && flt_valid === 1'b0,
        "R1", {28'b0, req_ready, rsp_valid, mem_rd_valid, flt_valid}, 32'h8);
    chk(flt_cause === 2'd0, "R1", {30'b0, flt_cause}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && flt_valid === 1'b0, "R1", {31'b0, req_ready}, 32'd1);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // directed: domain 2 granted read after reprogramming (R5)
    dom_rd_allow = 16'h0004;
    run_vec('{32'h0070_7ABC, 1'b0, 1'b0, 32'h2000_0401, 32'h1111_1022, 2'd0, 32'h1111_1ABC});
    // directed: domain 0 no longer readable gives a permission fault (R5)
    run_vec('{32'h0070_7ABC, 1'b0, 1'b0, 32'h2000_0401, 32'h1111_1002, 2'd3, 32'h0});
    // directed: bypass with a read (R8)
    run_vec('{32'h0000_0FFF, 1'b0, 1'b1, 32'h0, 32'h0, 2'd0, 32'h0000_0FFF});

    // directed: reset during a walk returns to the idle state (R1)
    @(negedge clk);
    bypass_en = 1'b0;
    req_valid = 1'b1;
    req_vaddr = 32'h0123_4000;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(mem_rd_valid === 1'b0 && req_ready === 1'b1, "R1", {31'b0, mem_rd_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule